// File: doc/BRIEF.md
# Prescaled Up/Down Timer with Capture

A 16-bit general-purpose timer with a small register file on a single-cycle byte-addressed write port and a combinational read port. A prescaler produces count ticks at one of four ratios of the clock. The counter moves up or down on each tick. In free-running mode it wraps through its full range. In periodic mode it reloads from a load register. Every wrap or reload raises a timeout flag. Software clears this flag through a write-only clear register, and that same write can optionally restart the count.

Sixteen external event lines are resynchronised inside the block, and one of them can be chosen. When capture is on, a rising edge on the chosen line copies the live count into a capture register and raises a capture-pending flag. A later capture overwrites the stored value. Everything runs in one clock domain.

Top module: `gp_timer16`

## Requirements
- R1: After reset every register reads 0x0000 and both interrupt outputs are low.
- R2: Reads are combinational. Offset 0x00 returns the load register, 0x04 the count, 0x08 the settings (bits 12:0), 0x10 the capture value and 0x1C the flags (bit 0 timeout, bit 1 capture pending). Offset 0x0C and every unused offset read as zero.
- R3: With settings bit 4 set, the count advances once every 1, 16, 256 or 32768 clocks for settings bits 1:0 equal to 0, 1, 2 or 3. The first advance comes one full period after enable.
- R4: Settings bit 2 = 1 makes each advance add one. Settings bit 2 = 0 makes each advance subtract one.
- R5: With settings bit 3 = 0 (free-running), an advance from 0xFFFF while counting up gives 0x0000, and an advance from 0x0000 while counting down gives 0xFFFF.
- R6: With settings bit 3 = 1 (periodic), an advance from the end value (0xFFFF up, 0x0000 down) loads the load register value instead.
- R7: While settings bit 4 is 0, the count holds, except for the loads listed in R8.
- R8: Writing the settings register so that bit 4 goes from 0 to 1 copies the load register into the count. Writing the load register while bit 4 is 0 also copies the written value into the count. Writing the load register while bit 4 is 1 leaves the count alone.
- R9: An advance from the end value sets the timeout flag and drives tmo_irq high. Writing 1 to bit 0 at 0x0C clears the flag, unless a new timeout happens in the same cycle, in which case the flag stays set.
- R10: When settings bit 7 is 1, writing 1 to bit 0 at 0x0C also copies the load register into the count. When bit 7 is 0, that write leaves the count alone.
- R11: With settings bit 12 set, a rising edge on the event line chosen by settings bits 11:8 is seen after two clocks of resynchronisation. It stores the count into the capture register and sets the capture flag, and a later edge overwrites the stored value. An edge on any other line, or an edge while bit 12 is 0, changes nothing.
- R12: Writing 1 to bit 1 at 0x0C clears the capture flag and drives cap_irq low, unless a capture happens in the same cycle, in which case the flag stays set.
- R13: The prescaler restarts from zero whenever the timer is disabled or a settings write changes bits 1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 5 | Byte address of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| events | input | 16 | Asynchronous event lines |
| tmo_irq | output | 1 | Timeout flag |
| cap_irq | output | 1 | Capture-pending flag |

## Verification
Two pairs of actions can land in the same cycle: a flag being set and software clearing it. A timeout can coincide with a clear of bit 0, and a capture edge can coincide with a clear of bit 1. The bench provokes this by issuing clear writes back to back while a short periodic count keeps expiring, and while event pulses arrive on the chosen line. A reference model, updated on every clock, decides each cycle that setting wins. The outputs and the read data are compared with it on every cycle, so any cycle where a clear wrongly beats a new event shows up as a miscompare.

// File: rtl/gp_timer16.sv
module gp_timer16 #(
  parameter int CNT_W  = 16,
  parameter int N_EVT  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic [N_EVT-1:0]  events,
  output logic              tmo_irq,
  output logic              cap_irq
);
  localparam int SEL_W = $clog2(N_EVT);
  localparam int PW    = 15;
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] A_FLG  = ADDR_W'(5'h1C);

  logic [CNT_W-1:0] load_q, count_q, cap_q, step;
  logic [12:0]      ctrl_q;
  logic [PW-1:0]    pc, lim;
  logic [N_EVT-1:0] s1, s2, s3;
  logic             tmo_f, cap_f;

  wire              up     = ctrl_q[2];
  wire              per    = ctrl_q[3];
  wire              en     = ctrl_q[4];
  wire              rld    = ctrl_q[7];
  wire [SEL_W-1:0]  sel    = ctrl_q[8 +: SEL_W];
  wire              capen  = ctrl_q[12];

  wire wr_ld   = wr_en && addr == A_LOAD;
  wire wr_ctl  = wr_en && addr == A_CTL;
  wire wr_clr  = wr_en && addr == A_CLR;
  wire clr_tmo = wr_clr && wdata[0];
  wire clr_cap = wr_clr && wdata[1];

  always_comb
    case (ctrl_q[1:0])
      2'd0:    lim = PW'(0);
      2'd1:    lim = PW'(15);
      2'd2:    lim = PW'(255);
      default: lim = PW'(32767);
    endcase

  wire tick    = en && pc == lim;
  wire pre_chg = wr_ctl && wdata[1:0] != ctrl_q[1:0];
  wire en_rise = wr_ctl && wdata[4] && !en;
  wire at_end  = up ? &count_q : count_q == '0;
  wire wrap    = tick && at_end;
  wire cap_hit = capen && s2[sel] && !s3[sel];

  assign step = (at_end && per) ? load_q : (up ? count_q + 1'b1 : count_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= '0;
      count_q <= '0;
      cap_q   <= '0;
      ctrl_q  <= '0;
      pc      <= '0;
      tmo_f   <= 1'b0;
      cap_f   <= 1'b0;
      s1      <= '0;
      s2      <= '0;
      s3      <= '0;
    end else begin
      if (wr_ld)  load_q <= wdata;
      if (wr_ctl) ctrl_q <= wdata[12:0];

      if (!en || pre_chg || tick) pc <= '0;
      else                        pc <= pc + 1'b1;

      if (en_rise)             count_q <= load_q;
      else if (wr_ld && !en)   count_q <= wdata;
      else if (clr_tmo && rld) count_q <= load_q;
      else if (tick)           count_q <= step;

      tmo_f <= wrap | (tmo_f & ~clr_tmo);
      cap_f <= cap_hit | (cap_f & ~clr_cap);
      if (cap_hit) cap_q <= count_q;

      s1 <= events;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_comb
    case (addr)
      A_LOAD:  rdata = load_q;
      A_CNT:   rdata = count_q;
      A_CTL:   rdata = CNT_W'(ctrl_q);
      A_CAP:   rdata = cap_q;
      A_FLG:   rdata = CNT_W'({cap_f, tmo_f});
      default: rdata = '0;
    endcase

  assign tmo_irq = tmo_f;
  assign cap_irq = cap_f;
endmodule

// File: rtl/gp_timer16_chk.sv
module gp_timer16_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic [12:0]       ctrl,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  load,
  input logic              tick,
  input logic              tmo,
  input logic              capf
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[4] && !wr_en) |=> $stable(count));

  assert_up_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl[2] && !(&count) && !wr_en) |=> count == CNT_W'($past(count) + 1'b1));

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl[2] && ctrl[3] && count == '0 && !wr_en) |=> count == $past(load));

  assert_tmo_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl[2] && count == '0) |=> tmo);

  assert_tmo_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(5'h0C) && wdata[0] && !ctrl[4]) |=> !tmo);

  assert_cap_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capf) |-> $past(ctrl[12]));
endmodule

bind gp_timer16 gp_timer16_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ctrl(ctrl_q), .count(count_q), .load(load_q), .tick(tick),
  .tmo(tmo_f), .capf(cap_f)
);

// File: tb/gp_timer16_test.sv
`timescale 1ns/1ps
module gp_timer16_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = 5'h04;
  logic [15:0] wdata = '0;
  logic [15:0] events = '0;
  logic [15:0] rdata;
  logic        tmo_irq, cap_irq;

  int    vectors = 0, miscompares = 0;
  bit    running = 1'b0, done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  gp_timer16 uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                  .rdata(rdata), .events(events), .tmo_irq(tmo_irq), .cap_irq(cap_irq));

  logic [15:0] m_load, m_cnt, m_cap, m_s1, m_s2, m_s3;
  logic [12:0] m_ctl;
  logic        m_tmo, m_cpf;
  int          m_pc;

  always @(posedge clk) begin : model
    int div;
    bit tk, endp, hit, clr0, clr1;
    logic [15:0] nxt;
    if (!rst_n) begin
      m_load = 0; m_cnt = 0; m_cap = 0; m_ctl = 0; m_tmo = 0; m_cpf = 0; m_pc = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      case (m_ctl[1:0]) 0: div = 1; 1: div = 16; 2: div = 256; default: div = 32768; endcase
      tk   = m_ctl[4] && (m_pc == div - 1);
      endp = m_ctl[2] ? (m_cnt == 16'hFFFF) : (m_cnt == 16'h0000);
      hit  = m_ctl[12] && m_s2[m_ctl[11:8]] && !m_s3[m_ctl[11:8]];
      clr0 = wr_en && addr == 5'h0C && wdata[0];
      clr1 = wr_en && addr == 5'h0C && wdata[1];
      nxt  = m_cnt;
      if (tk) begin
        if (endp && m_ctl[3]) nxt = m_load;
        else if (m_ctl[2])    nxt = m_cnt + 16'd1;
        else                  nxt = m_cnt - 16'd1;
      end
      if (clr0 && m_ctl[7]) nxt = m_load;
      if (wr_en && addr == 5'h00 && !m_ctl[4]) nxt = wdata;
      if (wr_en && addr == 5'h08 && wdata[4] && !m_ctl[4]) nxt = m_load;
      if (hit) m_cap = m_cnt;
      m_tmo = (tk && endp) || (m_tmo && !clr0);
      m_cpf = hit || (m_cpf && !clr1);
      if (!m_ctl[4] || tk || (wr_en && addr == 5'h08 && wdata[1:0] != m_ctl[1:0])) m_pc = 0;
      else m_pc = m_pc + 1;
      m_cnt = nxt;
      if (wr_en && addr == 5'h00) m_load = wdata;
      if (wr_en && addr == 5'h08) m_ctl = wdata[12:0];
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = events;
    end
  end

  function automatic logic [15:0] mread(logic [4:0] a);
    case (a)
      5'h00: return m_load;
      5'h04: return m_cnt;
      5'h08: return {3'b0, m_ctl};
      5'h10: return m_cap;
      5'h1C: return {14'b0, m_cpf, m_tmo};
      default: return 16'h0000;
    endcase
  endfunction

  always @(negedge clk) begin
    #1;
    if (running && !done) begin
      vectors++;
      if (rdata !== mread(addr)) begin
        miscompares++;
        $display("FAIL %s rdata @%h actual %h expected %h", cur_req, addr, rdata, mread(addr));
      end
      if (tmo_irq !== m_tmo) begin
        miscompares++;
        $display("FAIL R9 tmo_irq actual %b expected %b", tmo_irq, m_tmo);
      end
      if (cap_irq !== m_cpf) begin
        miscompares++;
        $display("FAIL R12 cap_irq actual %b expected %b", cap_irq, m_cpf);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
  endtask

  task automatic idle(input int n, input logic [4:0] a = 5'h04);
    repeat (n) begin @(negedge clk); wr_en = 1'b0; addr = a; end
  endtask

  task automatic pulse(input int b, input int w);
    @(negedge clk); wr_en = 1'b0; addr = 5'h04; events[b] = 1'b1;
    idle(w - 1);
    @(negedge clk); events[b] = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1; running = 1'b1;
    // R1: reset values
    cur_req = "R1";
    idle(1, 5'h00); idle(1, 5'h04); idle(1, 5'h08); idle(1, 5'h10); idle(1, 5'h1C);
    // R2: register map and zero reads
    cur_req = "R2";
    wr(5'h00, 16'h1234); idle(1, 5'h00); idle(1, 5'h0C); idle(1, 5'h14); idle(1, 5'h18);
    // R8: load write while disabled reaches the count
    cur_req = "R8";
    idle(1, 5'h04);
    wr(5'h08, 16'h0018); idle(5);
    wr(5'h00, 16'h0055); idle(3); idle(1, 5'h00);
    // R7: hold while disabled
    cur_req = "R7";
    wr(5'h08, 16'h0000); idle(6);
    // R6: periodic down with timeouts
    cur_req = "R6";
    wr(5'h00, 16'h0003); wr(5'h08, 16'h0018); idle(12); idle(1, 5'h1C);
    // R9: clear, and clears colliding with new timeouts
    cur_req = "R9";
    wr(5'h0C, 16'h0001); idle(2, 5'h1C);
    repeat (12) wr(5'h0C, 16'h0001);
    idle(3, 5'h1C);
    // R5/R4: free-running up through 0xFFFF, then down through 0
    cur_req = "R5";
    wr(5'h08, 16'h0000); wr(5'h00, 16'hFFFD); wr(5'h08, 16'h0014); idle(8);
    cur_req = "R4";
    wr(5'h08, 16'h0000); wr(5'h00, 16'h0002); wr(5'h08, 16'h0010); idle(6);
    wr(5'h00, 16'h7777); idle(3);
    // R10: reload on clear, only with bit 7
    cur_req = "R10";
    wr(5'h08, 16'h0000); wr(5'h00, 16'd100); wr(5'h08, 16'h0090); idle(5);
    wr(5'h0C, 16'h0001); idle(4);
    wr(5'h08, 16'h0010); idle(3); wr(5'h0C, 16'h0001); idle(4);
    // R3/R13: prescale ratios and restart on field change
    cur_req = "R3";
    wr(5'h08, 16'h0000); wr(5'h00, 16'h0000); wr(5'h08, 16'h0011); idle(40);
    cur_req = "R13";
    wr(5'h08, 16'h0012); idle(600);
    wr(5'h08, 16'h0011); idle(10); wr(5'h08, 16'h0011); idle(30);
    cur_req = "R3";
    wr(5'h08, 16'h0013); idle(66000);
    // R11: capture on line 3, overwrite, wrong line, disabled capture
    cur_req = "R11";
    wr(5'h08, 16'h1314); idle(5);
    pulse(3, 3); idle(4); idle(1, 5'h10);
    idle(6); pulse(3, 2); idle(4); idle(1, 5'h10);
    wr(5'h0C, 16'h0002); pulse(5, 3); idle(5, 5'h1C);
    wr(5'h08, 16'h0314); pulse(3, 3); idle(5, 5'h10);
    // R12: capture clear, and clears colliding with captures
    cur_req = "R12";
    wr(5'h08, 16'h1314); pulse(3, 2); idle(4, 5'h1C);
    wr(5'h0C, 16'h0002); idle(2, 5'h1C);
    @(negedge clk); wr_en = 1'b0; events[3] = 1'b1;
    repeat (6) wr(5'h0C, 16'h0002);
    @(negedge clk); wr_en = 1'b0; events[3] = 1'b0;
    idle(2, 5'h1C);
    @(negedge clk); wr_en = 1'b0; events[3] = 1'b1;
    repeat (2) wr(5'h0C, 16'h0002);
    idle(4, 5'h1C);
    finish_run();
  end
endmodule